// File: doc/BRIEF.md
# Programmable Duty Pulse Wave Generator

This block produces one square-wave audio voice. A CPU-rate clock enable is halved into an APU-rate tick. An 11-bit period value drives a down-counting divider. Each time that divider wraps, it steps an 8-position duty sequencer. The sequencer level gates a 4-bit volume value that comes from outside, normally an envelope unit, and the result is sent toward a mixer.

Software programs the voice through four byte-wide write-only registers, chosen by a 2-bit select and a write strobe:

| Select | Contents | Side effects |
|---|---|---|
| 0 | Duty shape in bits 7..6 | None on the step index |
| 1 | Belongs to the sweep unit | None in this block |
| 2 | Low 8 bits of the period | None |
| 3 | High 3 bits of the period in bits 2..0 | Restarts the sequencer and pulses the envelope restart |

The divider is not reset by any write. The length-counter-zero flag and the sweep-mute flag come from neighbouring units and silence the output. A period below 8 also silences the output.

The APU-rate pacing is a two-state machine with these states and transitions:

| State | On `cpu_ce` | Tick emitted |
|---|---|---|
| `PH_REST` (entered at reset) | Moves to `PH_STEP` | No |
| `PH_STEP` | Moves back to `PH_REST` | Yes, one APU tick |

When `cpu_ce` is low, the state is held.

Top module: `pulse_voice`

## Requirements
- R1: During reset and directly after it, `sample` is 0 and `env_restart` is 0. Period, duty, step index, divider count and phase all clear to zero.
- R2: The period is {high bits, low byte}. The low byte is written with select 2 (data bits 7..0). The high bits are written with select 3 (data bits 2..0). Data bits 7..3 of a select-3 write are ignored.
- R3: One APU tick occurs on every second `cpu_ce`, the first one on the second `cpu_ce` after reset. On each tick, the divider reloads the period t if its count is 0 and emits a sequencer step; otherwise it decrements. One full waveform therefore lasts 16*(t+1) `cpu_ce` pulses.
- R4: The step index starts at 0 and decrements by one, wrapping, on every divider wrap. Table entries are therefore visited in the order 0, 7, 6, 5, 4, 3, 2, 1.
- R5: The duty tables are given as entry 7 down to entry 0. Duty 0 is 1000_0000, duty 1 is 1100_0000, duty 2 is 1111_0000 and duty 3 is 0011_1111. The sequencer level is the entry at the current step index.
- R6: A select-0 write changes the duty from data bits 7..6 and leaves the step index unchanged.
- R7: A select-3 write sets the step index to 0 and leaves the divider count untouched. It also raises `env_restart` for exactly the one cycle after the write edge.
- R8: `sample` is 0 whenever `sweep_mute` is 1, `len_zero` is 1 or the sequencer level is 0. Otherwise, subject to R9, it equals `vol_in`.
- R9: A period below 8 forces `sample` to 0, even when every other gate is open.
- R10: A select-1 write has no effect on `sample`, the step index or the period.
- R11: While `cpu_ce` is low, the phase, divider count and step index hold. Register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ce | input | 1 | CPU-rate clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| vol_in | input | 4 | Volume from the envelope or constant volume |
| len_zero | input | 1 | Length counter is zero |
| sweep_mute | input | 1 | Sweep unit is muting the voice |
| sample | output | 4 | Gated volume toward the mixer |
| env_restart | output | 1 | One-cycle envelope restart pulse |

## Verification
Some behaviours are checked by assertions on every cycle:
- Ticks are never back to back.
- The divider reloads the period when it wraps.
- The step index moves by exactly one per divider wrap, holds otherwise, and goes to 0 on restart.
- A nonzero sample is only ever seen with both flags clear and a period of at least 8.
- The restart pulse only follows a select-3 write.

The remaining behaviours can only be shown by the bench's scenarios: that the waveform shape per duty matches the table, that the full waveform period is 16*(t+1) enables, that a select-1 write leaves the sound untouched, and that a duty change mid-waveform continues from the same step. For these, a cycle-accurate model driven by random and directed stimulus is compared with `sample` on every cycle.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

    typedef enum logic {
        PH_REST = 1'b0,
        PH_STEP = 1'b1
    } apu_phase_t;

    // Level of table entry idx for a duty code, for a table of 'steps' entries.
    function automatic logic duty_level(input logic [1:0] duty,
                                        input int unsigned idx,
                                        input int unsigned steps);
        logic lvl;
        unique case (duty)
            2'd0: lvl = (idx >= steps - steps / 8);
            2'd1: lvl = (idx >= steps - steps / 4);
            2'd2: lvl = (idx >= steps - steps / 2);
            2'd3: lvl = (idx <  steps - steps / 4);
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/pulse_regs.sv
module pulse_regs #(
    parameter int PERIOD_W = 11,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [PERIOD_W-1:0] period,
    output logic [1:0]          duty,
    output logic                restart,
    output logic                env_restart
);
    localparam int LOW_W = DATA_W;
    localparam int HI_W  = PERIOD_W - LOW_W;

    localparam logic [1:0] SEL_SHAPE = 2'd0;
    localparam logic [1:0] SEL_LOW   = 2'd2;
    localparam logic [1:0] SEL_HIGH  = 2'd3;

    assign restart = wr_en && (wr_sel == SEL_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period      <= '0;
            duty        <= '0;
            env_restart <= 1'b0;
        end else begin
            env_restart <= restart;
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_SHAPE: duty <= wr_data[DATA_W-1 -: 2];
                    SEL_LOW:   period[LOW_W-1:0] <= wr_data;
                    SEL_HIGH:  period[PERIOD_W-1:LOW_W] <= wr_data[HI_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    assert_env_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        env_restart |-> $past(wr_en && (wr_sel == SEL_HIGH)));

endmodule

// File: rtl/pulse_divider.sv
module pulse_divider
    import pulse_pkg::*;
#(
    parameter int PERIOD_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_ce,
    input  logic [PERIOD_W-1:0] period,
    output logic                seq_clk
);
    apu_phase_t          phase, phase_nx;
    logic                tick;
    logic [PERIOD_W-1:0] cnt;

    // Phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_REST;
        else        phase <= phase_nx;
    end

    // Next state and tick output
    always_comb begin
        phase_nx = phase;
        tick     = 1'b0;
        unique case (phase)
            PH_REST: if (cpu_ce) phase_nx = PH_STEP;
            PH_STEP: if (cpu_ce) begin
                phase_nx = PH_REST;
                tick     = 1'b1;
            end
        endcase
    end

    assign seq_clk = tick && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= (cnt == '0) ? period : cnt - 1'b1;
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clk |=> (cnt == $past(period)));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ce |=> ($stable(cnt) && $stable(phase)));

endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
    import pulse_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_clk,
    input  logic       restart,
    input  logic [1:0] duty,
    output logic       level
);
    localparam int STEP_W = $clog2(STEPS);

    logic [STEP_W-1:0] step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        step <= '0;
        else if (restart)  step <= '0;
        else if (seq_clk)  step <= step - 1'b1;
    end

    assign level = duty_level(duty, 32'(step), STEPS);

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_clk && !restart) |=> (step == $past(step) - 1'b1));
    assert_step_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_clk && !restart) |=> $stable(step));
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (step == '0));

endmodule

// File: rtl/pulse_voice.sv
module pulse_voice #(
    parameter int PERIOD_W   = 11,
    parameter int STEPS      = 8,
    parameter int VOL_W      = 4,
    parameter int MIN_PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ce,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [VOL_W-1:0] vol_in,
    input  logic             len_zero,
    input  logic             sweep_mute,
    output logic [VOL_W-1:0] sample,
    output logic             env_restart
);
    logic [PERIOD_W-1:0] period;
    logic [1:0]          duty;
    logic                restart;
    logic                seq_clk;
    logic                level;
    logic                too_short;

    pulse_regs #(.PERIOD_W(PERIOD_W), .DATA_W(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period(period), .duty(duty),
        .restart(restart), .env_restart(env_restart)
    );

    pulse_divider #(.PERIOD_W(PERIOD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce),
        .period(period), .seq_clk(seq_clk)
    );

    pulse_seq #(.STEPS(STEPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .seq_clk(seq_clk),
        .restart(restart), .duty(duty), .level(level)
    );

    assign too_short = (period < PERIOD_W'(MIN_PERIOD));

    always_comb begin
        if (level && !sweep_mute && !len_zero && !too_short) sample = vol_in;
        else                                                 sample = '0;
    end

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample != '0) |-> (!sweep_mute && !len_zero));
    assert_min_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample != '0) |-> (period >= PERIOD_W'(MIN_PERIOD)));

endmodule

// File: tb/sim_pulse_voice.sv
module sim_pulse_voice;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_ce = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] vol_in = 4'd0;
    logic       len_zero = 1'b0;
    logic       sweep_mute = 1'b0;
    logic [3:0] sample;
    logic       env_restart;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    pulse_voice u0 (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .vol_in(vol_in),
        .len_zero(len_zero), .sweep_mute(sweep_mute),
        .sample(sample), .env_restart(env_restart)
    );

    // Reference model state, built from the requirements
    bit        m_ph;
    bit [10:0] m_cnt, m_per;
    bit [2:0]  m_step;
    bit [1:0]  m_duty;
    bit        m_env;

    // R5 tables, bit i = entry i
    function automatic bit tbl(input bit [1:0] d, input bit [2:0] i);
        bit [7:0] t;
        case (d)
            2'd0: t = 8'b1000_0000;
            2'd1: t = 8'b1100_0000;
            2'd2: t = 8'b1111_0000;
            default: t = 8'b0011_1111;
        endcase
        return t[i];
    endfunction

    function automatic bit [3:0] exp_sample();
        if (tbl(m_duty, m_step) && !sweep_mute && !len_zero && m_per >= 11'd8)
            return vol_in;
        return 4'd0;
    endfunction

    always @(posedge clk) begin
        bit tk, rs, sq;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_per = 0; m_step = 0; m_duty = 0; m_env = 0;
        end else begin
            tk = cpu_ce && m_ph;
            if (cpu_ce) m_ph = !m_ph;
            rs = wr_en && wr_sel == 2'd3;
            sq = tk && m_cnt == 0;
            if (tk) m_cnt = (m_cnt == 0) ? m_per : m_cnt - 1;
            if (rs) m_step = 0;
            else if (sq) m_step = m_step - 1;
            m_env = rs;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_duty = wr_data[7:6];
                    2'd2: m_per[7:0] = wr_data;
                    2'd3: m_per[10:8] = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // one clock: wait for negedge, compare against model, return for new inputs
    task automatic tick1();
        @(negedge clk);
        cyc++;
        check(tag, sample, exp_sample(), "sample");
        check(tag, env_restart, m_env, "env_restart");
    endtask

    task automatic wr(input bit [1:0] s, input bit [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick1();
        wr_en = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int last_rise;
        int gap;
        bit prev;
        void'($urandom(32'd20240611));
        vol_in = 4'hF;
        run(3);
        // R1: reset state
        check("R1", sample, 0, "sample in reset");
        check("R1", env_restart, 0, "env_restart in reset");
        rst_n = 1;
        cpu_ce = 1;
        run(20);

        // R2 + R3: period 9 with duty 2, measure the waveform period
        tag = "R2";
        wr(2'd0, 8'h80);
        wr(2'd2, 8'd9);
        wr(2'd3, 8'hF8);          // upper bits 7..3 must be ignored (R2)
        tag = "R3";
        last_rise = -1; gap = 0; prev = (sample != 0);
        for (int i = 0; i < 500; i++) begin
            tick1();
            if (!prev && sample != 0) begin
                if (last_rise >= 0) gap = cyc - last_rise;
                last_rise = cyc;
            end
            prev = (sample != 0);
        end
        check("R3", gap, 160, "waveform period in cpu_ce pulses");

        // R4/R5: every duty, each restarted, with a short period
        wr(2'd2, 8'd8);
        for (int d = 0; d < 4; d++) begin
            tag = (d[0]) ? "R5" : "R4";
            wr(2'd0, 8'(d << 6));
            wr(2'd3, 8'd0);
            run(200);
        end

        // R6: change duty mid-waveform
        tag = "R6";
        for (int i = 0; i < 12; i++) begin
            run(7 + i);
            wr(2'd0, 8'($urandom_range(0, 3) << 6));
        end

        // R7: restart pulse timing and no divider reset
        tag = "R7";
        wr(2'd3, 8'd0);
        check("R7", env_restart, 1, "env_restart after high write");
        tick1();
        check("R7", env_restart, 0, "env_restart one cycle only");
        run(37);
        wr(2'd3, 8'd0);
        run(60);

        // R8: gate flags
        tag = "R8";
        for (int i = 0; i < 150; i++) begin
            len_zero = ($urandom_range(0, 3) == 0);
            sweep_mute = ($urandom_range(0, 3) == 0);
            vol_in = 4'($urandom);
            tick1();
        end
        len_zero = 0; sweep_mute = 0; vol_in = 4'hA;

        // R9: periods 7 and below silence, 8 does not
        tag = "R9";
        wr(2'd0, 8'hC0);
        wr(2'd2, 8'd7);
        wr(2'd3, 8'd0);
        run(120);
        check("R9", sample, 0, "sample with period 7");
        wr(2'd2, 8'd0);
        run(40);

        // R10: sweep register writes ignored
        tag = "R10";
        wr(2'd2, 8'd12);
        for (int i = 0; i < 60; i++) begin
            wr(2'd1, 8'($urandom));
            run(3);
        end

        // R11: sparse and stalled enables
        tag = "R11";
        for (int i = 0; i < 600; i++) begin
            cpu_ce = (i % 50 < 20) ? 1'b0 : ($urandom_range(0, 2) == 0);
            tick1();
        end

        // mixed random traffic
        tag = "R2";
        for (int i = 0; i < 20000; i++) begin
            cpu_ce = ($urandom_range(0, 3) != 0);
            vol_in = 4'($urandom);
            len_zero = ($urandom_range(0, 15) == 0);
            sweep_mute = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 40) == 0) begin
                bit [1:0] s = 2'($urandom);
                bit [7:0] d = 8'($urandom);
                if (s == 2'd2) d = 8'($urandom_range(0, 24));
                if (s == 2'd3) d = d & 8'hF8;
                wr(s, d);
            end else tick1();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule